// File: doc/BRIEF.md
# LED Strip Command Processor

This block sits between a byte-oriented request channel and the frame shifter of an addressable LED strip. Each request packet is a run of bytes on a valid/ready stream. The first byte carries an opcode and the byte flagged with `req_last` closes the packet. The block decodes the packet and checks its arguments. It holds the strip configuration (pixel format and pixel count) and a byte-addressed framebuffer RAM. Every packet is answered on a response stream: a status byte, followed by an 8-byte info record when an info query succeeds.

The block starts the external shifter with a one-cycle `shift_start` pulse when the strip needs a new frame. This happens after a pixel write, after a configuration change, and after a clear. The status reply for these commands is held back until the shifter pulses `shift_done`. The shifter reads the framebuffer through a dedicated synchronous read port.

Pixel writes first go to a staging RAM. They are copied into the framebuffer only after the full length of the packet is known and has passed the bounds check. A rejected write therefore never changes the visible frame.

The controller is one state machine. Its states are:
- OPCODE: wait for the first byte.
- HEADER: collect the index and argument bytes.
- CHECK: validate the header.
- DATA: stage the write bytes.
- DRAIN: discard trailing bytes.
- EXEC: final status, and apply the configuration.
- ZERO: clear the framebuffer, one byte per cycle.
- COPY and FLUSH: move the staged bytes into the framebuffer.
- KICK: pulse `shift_start`.
- WAIT: wait for `shift_done`.
- REPLY: send the response bytes.

Transitions:
- OPCODE→HEADER for an opcode that has arguments.
- OPCODE→DRAIN or EXEC for an info query or an unknown opcode.
- HEADER→CHECK when the header is complete.
- HEADER→EXEC when the packet ends early.
- CHECK→DATA for a write that carries data bytes.
- CHECK→DRAIN for other commands that carry extra bytes.
- CHECK→EXEC when the packet has ended.
- DATA or DRAIN→EXEC on the last byte.
- EXEC→ZERO for a configure or clear that passed.
- EXEC→COPY (or straight to KICK when there is no data) for a write that passed.
- EXEC→REPLY for an info query or any error.
- ZERO→KICK at the last address.
- COPY→FLUSH→KICK after the last staged byte.
- KICK→WAIT.
- WAIT→REPLY on `shift_done`.
- REPLY→OPCODE when the last response byte is taken.

Top module: `led_cmd_proc`

## Requirements
- R1: The opcode byte 0x00 is an info query. It replies with status 0 followed by 8 bytes: universe count 1, the `DATA_PIN` parameter, the current format, a zero byte, the pixel count low then high byte, and `MAX_PIXELS` low then high byte. After reset the format is 0 and the pixel count is 1.
- R2: The opcodes are 0x01 configure, 0x02 write and 0x03 clear. Any other opcode byte gets the single status byte 3 (not supported). It changes no state and does not start the shifter.
- R3: Configure, write and clear each begin with an index byte. A non-zero index gets status 1 (no such universe), changes nothing and does not start the shifter.
- R4: The configure arguments are an index byte, a format byte and a little-endian 16-bit pixel count. A format above 2, or a count outside 1 to `MAX_PIXELS`, gets status 2 (invalid) and leaves the configuration unchanged.
- R5: A successful configure gets status 0. It loads the new format and count, zeroes every framebuffer byte, and then starts the shifter.
- R6: The write arguments are an index byte and a little-endian 16-bit byte offset, followed by data bytes. Data byte i lands at framebuffer address offset+i, and all other bytes keep their earlier contents across commands.
- R7: A write whose offset plus data length exceeds pixel count × bytes per pixel gets status 2. Bytes per pixel are 3 for formats 0 and 1, and 4 for format 2. Such a write leaves the framebuffer unchanged and does not start the shifter. A write that ends exactly at the limit is accepted.
- R8: A clear with index 0 zeroes every framebuffer byte, starts the shifter and gets status 0.
- R9: `shift_start` is a single-cycle pulse. The status reply to a successful configure, write or clear appears only after `shift_done`.
- R10: The response begins with the status byte. `rsp_last` marks the final byte: the 9th for a successful info query, and the 1st for everything else. Response data stays stable while it waits for `rsp_ready`.
- R11: A configure, write or clear packet that ends before its arguments are complete gets status 2 and changes nothing.
- R12: `req_ready` is low from the end of a packet until its last response byte has been accepted, so requests and responses never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request byte valid |
| req_data | input | 8 | Request byte |
| req_last | input | 1 | Final byte of the request packet |
| req_ready | output | 1 | Request byte accepted when high with `req_valid` |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| rsp_ready | input | 1 | Response byte taken |
| shift_start | output | 1 | One-cycle pulse starting a frame shift |
| shift_done | input | 1 | Pulse from the shifter when the frame and latch are done |
| fb_rd_addr | input | FB_AW | Framebuffer read address |
| fb_rd_data | output | 8 | Framebuffer read data, one cycle after the address |
| cfg_format | output | 2 | Current pixel format |
| cfg_pixels | output | 16 | Current pixel count |

## Verification
The checker assumes the following about the block's inputs:
- `shift_done` pulses only while the block waits after its own `shift_start`.
- Every request packet ends with a byte flagged `req_last`.
- The response consumer does not go away while a reply is pending.

The bench keeps within these rules. Its shifter model answers each start exactly once, after a fixed delay, and raises `shift_done` for one cycle only. Every request it builds has its last byte flagged, and it holds `rsp_ready` high.

// File: rtl/led_cmd_pkg.sv
package led_cmd_pkg;

    localparam logic [7:0] OP_INFO  = 8'h00;
    localparam logic [7:0] OP_CFG   = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_CLEAR = 8'h03;

    localparam logic [7:0] ST_OK      = 8'd0;
    localparam logic [7:0] ST_NOENT   = 8'd1;
    localparam logic [7:0] ST_INVALID = 8'd2;
    localparam logic [7:0] ST_NOSUP   = 8'd3;

    typedef enum logic [3:0] {
        S_OPCODE, S_HEADER, S_CHECK, S_DATA, S_DRAIN, S_EXEC,
        S_ZERO, S_COPY, S_FLUSH, S_KICK, S_WAIT, S_REPLY
    } state_t;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_INFO, ACT_CFG, ACT_WRITE, ACT_CLEAR
    } act_t;

endpackage

// File: rtl/led_byte_ram.sv
module led_byte_ram #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/led_arg_check.sv
module led_arg_check
    import led_cmd_pkg::*;
#(
    parameter int MAX_PIXELS = 64
) (
    input  logic [7:0]  opc,
    input  logic [7:0]  idx,
    input  logic [7:0]  fmt_arg,
    input  logic [15:0] cnt_arg,
    input  logic [1:0]  cur_fmt,
    input  logic [15:0] cur_pix,
    input  logic [15:0] wr_off,
    input  logic [16:0] wr_len,
    output logic [7:0]  hdr_status,
    output logic        wr_fits
);
    logic [17:0] limit;
    logic [17:0] end_pos;

    always_comb begin
        if (idx != 8'd0) begin
            hdr_status = ST_NOENT;
        end else if (opc == OP_CFG &&
                     (fmt_arg > 8'd2 || cnt_arg == 16'd0 ||
                      32'(cnt_arg) > MAX_PIXELS)) begin
            hdr_status = ST_INVALID;
        end else begin
            hdr_status = ST_OK;
        end
    end

    // three bytes per pixel, plus one more for the four-channel format
    assign limit   = ({2'b00, cur_pix} << 1) + {2'b00, cur_pix} +
                     ((cur_fmt == 2'd2) ? {2'b00, cur_pix} : 18'd0);
    assign end_pos = {2'b00, wr_off} + {1'b0, wr_len};
    assign wr_fits = (end_pos <= limit);
endmodule

// File: rtl/led_rsp_mux.sv
module led_rsp_mux #(
    parameter int MAX_PIXELS = 64,
    parameter int DATA_PIN   = 16
) (
    input  logic [3:0]  ridx,
    input  logic [7:0]  status,
    input  logic [1:0]  cur_fmt,
    input  logic [15:0] cur_pix,
    output logic [7:0]  byte_out
);
    localparam logic [15:0] MAXW = 16'(MAX_PIXELS);
    localparam logic [7:0]  PINW = 8'(DATA_PIN);

    always_comb begin
        unique case (ridx)
            4'd0:    byte_out = status;
            4'd1:    byte_out = 8'd1;
            4'd2:    byte_out = PINW;
            4'd3:    byte_out = {6'd0, cur_fmt};
            4'd4:    byte_out = 8'd0;
            4'd5:    byte_out = cur_pix[7:0];
            4'd6:    byte_out = cur_pix[15:8];
            4'd7:    byte_out = MAXW[7:0];
            4'd8:    byte_out = MAXW[15:8];
            default: byte_out = 8'd0;
        endcase
    end
endmodule

// File: rtl/led_cmd_proc.sv
module led_cmd_proc
    import led_cmd_pkg::*;
#(
    parameter int MAX_PIXELS = 64,
    parameter int DATA_PIN   = 16,
    localparam int FB_BYTES  = 4 * MAX_PIXELS,
    localparam int FB_AW     = $clog2(FB_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_data,
    input  logic             req_last,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_last,
    input  logic             rsp_ready,
    output logic             shift_start,
    input  logic             shift_done,
    input  logic [FB_AW-1:0] fb_rd_addr,
    output logic [7:0]       fb_rd_data,
    output logic [1:0]       cfg_format,
    output logic [15:0]      cfg_pixels
);
    localparam logic [FB_AW:0] PTR_LAST = (FB_AW+1)'(FB_BYTES - 1);

    state_t      state, state_nx;
    act_t        act_q;
    logic [7:0]  opc_q, idx_q, fmt_q, status_q;
    logic [15:0] cnt_q, off_q;
    logic [16:0] dcnt_q;
    logic [1:0]  hcnt_q, hlast;
    logic        more_q;
    logic [FB_AW:0] ptr_q;
    logic [3:0]  ridx_q;
    logic        cp_vld_q;
    logic [FB_AW-1:0] cp_addr_q;

    logic        acc, hdr_done, known_op, info_reply, wr_fits, exec_ok;
    logic [7:0]  hdr_status, exec_status, reply_byte;
    logic [17:0] stage_pos;
    logic [FB_AW-1:0] copy_addr;
    logic        stage_we, frame_we;
    logic [FB_AW-1:0] frame_waddr;
    logic [7:0]  frame_wdata, stage_rdata;

    led_arg_check #(.MAX_PIXELS(MAX_PIXELS)) u_check (
        .opc(opc_q), .idx(idx_q), .fmt_arg(fmt_q), .cnt_arg(cnt_q),
        .cur_fmt(cfg_format), .cur_pix(cfg_pixels),
        .wr_off(off_q), .wr_len(dcnt_q),
        .hdr_status(hdr_status), .wr_fits(wr_fits)
    );

    led_rsp_mux #(.MAX_PIXELS(MAX_PIXELS), .DATA_PIN(DATA_PIN)) u_rsp (
        .ridx(ridx_q), .status(status_q), .cur_fmt(cfg_format),
        .cur_pix(cfg_pixels), .byte_out(reply_byte)
    );

    led_byte_ram #(.DEPTH(FB_BYTES)) u_stage (
        .clk(clk), .we(stage_we), .waddr(stage_pos[FB_AW-1:0]),
        .wdata(req_data), .raddr(copy_addr), .rdata(stage_rdata)
    );

    led_byte_ram #(.DEPTH(FB_BYTES)) u_frame (
        .clk(clk), .we(frame_we), .waddr(frame_waddr),
        .wdata(frame_wdata), .raddr(fb_rd_addr), .rdata(fb_rd_data)
    );

    // ---------------- decode helpers ----------------
    assign acc      = req_valid && req_ready;
    assign known_op = (req_data == OP_CFG) || (req_data == OP_WRITE) ||
                      (req_data == OP_CLEAR);
    always_comb begin
        unique case (opc_q)
            OP_CFG:   hlast = 2'd3;
            OP_WRITE: hlast = 2'd2;
            default:  hlast = 2'd0;
        endcase
    end
    assign hdr_done  = (hcnt_q == hlast);
    assign stage_pos = {2'b00, off_q} + {1'b0, dcnt_q};
    assign copy_addr = FB_AW'({2'b00, off_q} + 18'(ptr_q));

    always_comb begin
        if (status_q != ST_OK)                   exec_status = status_q;
        else if (act_q == ACT_WRITE && !wr_fits) exec_status = ST_INVALID;
        else                                     exec_status = ST_OK;
    end
    assign exec_ok    = (exec_status == ST_OK);
    assign info_reply = (act_q == ACT_INFO) && (status_q == ST_OK);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OPCODE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OPCODE: if (acc) begin
                if (known_op) state_nx = req_last ? S_EXEC : S_HEADER;
                else          state_nx = req_last ? S_EXEC : S_DRAIN;
            end
            S_HEADER: if (acc) begin
                if (hdr_done)      state_nx = S_CHECK;
                else if (req_last) state_nx = S_EXEC;
            end
            S_CHECK: begin
                if (!more_q)               state_nx = S_EXEC;
                else if (opc_q == OP_WRITE) state_nx = S_DATA;
                else                       state_nx = S_DRAIN;
            end
            S_DATA, S_DRAIN: if (acc && req_last) state_nx = S_EXEC;
            S_EXEC: begin
                if (!exec_ok) state_nx = S_REPLY;
                else begin
                    unique case (act_q)
                        ACT_CFG, ACT_CLEAR: state_nx = S_ZERO;
                        ACT_WRITE: state_nx = (dcnt_q == 17'd0) ? S_KICK : S_COPY;
                        default:   state_nx = S_REPLY;
                    endcase
                end
            end
            S_ZERO:  if (ptr_q == PTR_LAST) state_nx = S_KICK;
            S_COPY:  if (17'(ptr_q) == dcnt_q - 17'd1) state_nx = S_FLUSH;
            S_FLUSH: state_nx = S_KICK;
            S_KICK:  state_nx = S_WAIT;
            S_WAIT:  if (shift_done) state_nx = S_REPLY;
            S_REPLY: if (rsp_ready && rsp_last) state_nx = S_OPCODE;
            default: state_nx = S_OPCODE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready   = (state == S_OPCODE) || (state == S_HEADER) ||
                      (state == S_DATA)   || (state == S_DRAIN);
        rsp_valid   = (state == S_REPLY);
        rsp_data    = reply_byte;
        rsp_last    = rsp_valid && (ridx_q == (info_reply ? 4'd8 : 4'd0));
        shift_start = (state == S_KICK);
        stage_we    = (state == S_DATA) && acc && (stage_pos < 18'(FB_BYTES));
        frame_we    = (state == S_ZERO) || cp_vld_q;
        frame_waddr = (state == S_ZERO) ? ptr_q[FB_AW-1:0] : cp_addr_q;
        frame_wdata = (state == S_ZERO) ? 8'd0 : stage_rdata;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= ACT_NONE;   opc_q <= '0;  idx_q <= '0;  fmt_q <= '0;
            status_q <= ST_OK;   cnt_q <= '0;  off_q <= '0;  dcnt_q <= '0;
            hcnt_q <= '0;        more_q <= 1'b0; ptr_q <= '0; ridx_q <= '0;
            cp_vld_q <= 1'b0;    cp_addr_q <= '0;
            cfg_format <= 2'd0;  cfg_pixels <= 16'd1;
        end else begin
            cp_vld_q  <= (state == S_COPY);
            cp_addr_q <= copy_addr;
            unique case (state)
                S_OPCODE: if (acc) begin
                    opc_q  <= req_data;
                    hcnt_q <= '0;
                    dcnt_q <= '0;
                    idx_q  <= '0;
                    unique case (req_data)
                        OP_INFO:  act_q <= ACT_INFO;
                        OP_CFG:   act_q <= ACT_CFG;
                        OP_WRITE: act_q <= ACT_WRITE;
                        OP_CLEAR: act_q <= ACT_CLEAR;
                        default:  act_q <= ACT_NONE;
                    endcase
                    if (req_data == OP_INFO)        status_q <= ST_OK;
                    else if (!known_op)             status_q <= ST_NOSUP;
                    else if (req_last)              status_q <= ST_INVALID;
                    else                            status_q <= ST_OK;
                end
                S_HEADER: if (acc) begin
                    hcnt_q <= hcnt_q + 2'd1;
                    more_q <= !req_last;
                    unique case (hcnt_q)
                        2'd0: idx_q <= req_data;
                        2'd1: if (opc_q == OP_CFG) fmt_q <= req_data;
                              else off_q[7:0] <= req_data;
                        2'd2: if (opc_q == OP_CFG) cnt_q[7:0] <= req_data;
                              else off_q[15:8] <= req_data;
                        default: cnt_q[15:8] <= req_data;
                    endcase
                    if (!hdr_done && req_last) status_q <= ST_INVALID;
                end
                S_CHECK: status_q <= hdr_status;
                S_DATA: if (acc && dcnt_q != '1) dcnt_q <= dcnt_q + 17'd1;
                S_EXEC: begin
                    status_q <= exec_status;
                    ptr_q    <= '0;
                    if (exec_ok && act_q == ACT_CFG) begin
                        cfg_format <= fmt_q[1:0];
                        cfg_pixels <= cnt_q;
                    end
                end
                S_ZERO, S_COPY: ptr_q <= ptr_q + 1'b1;
                S_REPLY: if (rsp_ready) ridx_q <= rsp_last ? 4'd0 : ridx_q + 4'd1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/led_cmd_proc_chk.sv
module led_cmd_proc_chk #(
    parameter int MAX_PIXELS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [7:0]  rsp_data,
    input logic        rsp_last,
    input logic        rsp_ready,
    input logic        shift_start,
    input logic [1:0]  cfg_format,
    input logic [15:0] cfg_pixels
);
    // R9: the shifter trigger never lasts longer than one cycle
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_start |=> !shift_start);

    // R9: no frame is started while a reply is being sent
    p_no_start_in_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !shift_start);

    // R12: request intake and reply never overlap
    p_half_duplex_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    // R10: a stalled reply byte is held unchanged
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

    // R4: the configuration only ever holds legal values
    p_cfg_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_format <= 2'd2) && (cfg_pixels >= 16'd1) && (32'(cfg_pixels) <= MAX_PIXELS));

    // R5: the configuration changes only while a command is executing
    p_cfg_change_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_pixels) || !$stable(cfg_format)) |-> (!req_ready && !rsp_valid));
endmodule

bind led_cmd_proc led_cmd_proc_chk #(.MAX_PIXELS(MAX_PIXELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_ready(rsp_ready),
    .shift_start(shift_start), .cfg_format(cfg_format), .cfg_pixels(cfg_pixels)
);

// File: tb/led_cmd_proc_bench.sv
module led_cmd_proc_bench;
    localparam int MAXP = 64;
    localparam int PIN  = 16;
    localparam int FBN  = 4 * MAXP;
    localparam int AW   = $clog2(FBN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_last = 1'b0, rsp_ready = 1'b1, shift_done = 1'b0;
    logic [7:0] req_data = '0;
    logic req_ready, rsp_valid, rsp_last, shift_start;
    logic [7:0] rsp_data, fb_rd_data;
    logic [AW-1:0] fb_rd_addr = '0;
    logic [1:0] cfg_format;
    logic [15:0] cfg_pixels;

    always #2 clk = ~clk;

    led_cmd_proc #(.MAX_PIXELS(MAXP), .DATA_PIN(PIN)) u_led_cmd_proc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_last(req_last), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_ready(rsp_ready),
        .shift_start(shift_start), .shift_done(shift_done),
        .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
        .cfg_format(cfg_format), .cfg_pixels(cfg_pixels)
    );

    int n_tests = 0, n_fail = 0, n_starts = 0;
    bit shift_busy = 1'b0, early_reply = 1'b0;
    logic [7:0] pkt [16];
    logic [7:0] rb [16];
    int rn;

    // shifter model: answers each start once after a fixed delay
    initial begin
        forever begin
            @(negedge clk);
            if (shift_start) begin
                n_starts++;
                shift_busy = 1'b1;
                repeat (20) @(negedge clk);
                shift_done = 1'b1;
                @(posedge clk);
                #1 shift_done = 1'b0;
                shift_busy = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_pkt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_data = pkt[i]; req_last = (i == n - 1);
            while (!req_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0; req_last = 1'b0;
    endtask

    task automatic collect();
        bit fin = 1'b0;
        rn = 0;
        while (!fin) begin
            @(negedge clk);
            if (rsp_valid) begin
                if (shift_busy) early_reply = 1'b1;
                rb[rn] = rsp_data;
                rn++;
                if (rsp_last || rn == 16) fin = 1'b1;
            end
        end
    endtask

    task automatic run(input int n);
        fork
            send_pkt(n);
            collect();
        join
    endtask

    task automatic rd_fb(input int a, output int v);
        @(negedge clk); fb_rd_addr = AW'(a);
        @(negedge clk); v = int'(fb_rd_data);
    endtask

    task automatic do_cfg(input int idx, input int fmt, input int cnt);
        pkt[0] = 8'h01; pkt[1] = 8'(idx); pkt[2] = 8'(fmt);
        pkt[3] = 8'(cnt); pkt[4] = 8'(cnt >> 8);
        run(5);
    endtask

    task automatic do_write(input int idx, input int off, input int nd, input int base);
        pkt[0] = 8'h02; pkt[1] = 8'(idx); pkt[2] = 8'(off); pkt[3] = 8'(off >> 8);
        for (int i = 0; i < nd; i++) pkt[4 + i] = 8'(base + i);
        run(4 + nd);
    endtask

    task automatic chk_info(input string tag, input int fmt, input int pix);
        pkt[0] = 8'h00;
        run(1);
        chk({tag, " len"}, rn, 9);
        chk({tag, " status"}, rb[0], 0);
        chk({tag, " count"}, rb[1], 1);
        chk({tag, " pin"}, rb[2], PIN);
        chk({tag, " fmt"}, rb[3], fmt);
        chk({tag, " rsvd"}, rb[4], 0);
        chk({tag, " pix"}, {rb[6], rb[5]}, pix);
        chk({tag, " max"}, {rb[8], rb[7]}, MAXP);
    endtask

    task automatic chk_fb_zero(input string tag);
        int bad = 0, v;
        for (int a = 0; a < FBN; a++) begin
            rd_fb(a, v);
            if (v != 0) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic t_reset_r1();
        chk("R1 reset fmt port", cfg_format, 0);
        chk_info("R1 reset info", 0, 1);
    endtask

    task automatic t_config_r5();
        int s0 = n_starts;
        early_reply = 1'b0;
        do_cfg(0, 2, 4);
        chk("R5 cfg status", rb[0], 0);
        chk("R10 cfg reply length", rn, 1);
        chk("R5 cfg started shift", n_starts - s0, 1);
        chk("R9 cfg reply after done", early_reply, 0);
        chk_info("R5 cfg info", 2, 4);
        chk_fb_zero("R5 cfg zeroed");
    endtask

    task automatic t_write_r6();
        int v, s0 = n_starts;
        early_reply = 1'b0;
        do_write(0, 2, 3, 8'hA1);
        chk("R6 write status", rb[0], 0);
        chk("R9 write shift", n_starts - s0, 1);
        chk("R9 write reply after done", early_reply, 0);
        for (int i = 0; i < 3; i++) begin rd_fb(2 + i, v); chk("R6 write byte", v, 8'hA1 + i); end
        rd_fb(1, v); chk("R6 below untouched", v, 0);
        rd_fb(5, v); chk("R6 above untouched", v, 0);
        do_write(0, 10, 1, 8'hB1);
        rd_fb(10, v); chk("R6 second write", v, 8'hB1);
        rd_fb(3, v);  chk("R6 persistence", v, 8'hA2);
    endtask

    task automatic t_limit_r7();
        int v, s0;
        do_write(0, 13, 3, 8'hC0);
        chk("R7 exact fit status", rb[0], 0);
        rd_fb(15, v); chk("R7 exact fit last byte", v, 8'hC2);
        s0 = n_starts;
        do_write(0, 14, 3, 8'hE0);
        chk("R7 overflow status", rb[0], 2);
        chk("R7 overflow no shift", n_starts - s0, 0);
        rd_fb(14, v); chk("R7 overflow fb unchanged", v, 8'hC1);
        do_cfg(0, 0, 4);
        do_write(0, 10, 3, 8'h50);
        chk("R7 three-byte limit rejects", rb[0], 2);
        rd_fb(10, v); chk("R7 three-byte reject unchanged", v, 0);
        do_write(0, 9, 3, 8'h60);
        chk("R7 three-byte limit fits", rb[0], 0);
        rd_fb(11, v); chk("R7 three-byte tail", v, 8'h62);
    endtask

    task automatic t_index_r3();
        int v, s0 = n_starts;
        do_write(1, 0, 2, 8'h77);
        chk("R3 write idx status", rb[0], 1);
        rd_fb(0, v); chk("R3 write idx fb", v, 0);
        pkt[0] = 8'h03; pkt[1] = 8'h02; run(2);
        chk("R3 clear idx status", rb[0], 1);
        rd_fb(11, v); chk("R3 clear idx fb", v, 8'h62);
        do_cfg(5, 1, 2);
        chk("R3 cfg idx status", rb[0], 1);
        chk("R3 no shift", n_starts - s0, 0);
        chk_info("R3 cfg unchanged", 0, 4);
    endtask

    task automatic t_cfg_bad_r4();
        do_cfg(0, 3, 4);  chk("R4 bad format", rb[0], 2);
        do_cfg(0, 1, 0);  chk("R4 zero count", rb[0], 2);
        do_cfg(0, 1, MAXP + 1); chk("R4 count over max", rb[0], 2);
        chk_info("R4 config kept", 0, 4);
        do_cfg(0, 1, MAXP); chk("R4 count at max", rb[0], 0);
        chk("R4 pixels port", cfg_pixels, MAXP);
    endtask

    task automatic t_unknown_r2();
        int s0 = n_starts;
        pkt[0] = 8'h07; pkt[1] = 8'h00; pkt[2] = 8'h11; run(3);
        chk("R2 unknown status", rb[0], 3);
        chk("R2 unknown length", rn, 1);
        chk("R2 unknown no shift", n_starts - s0, 0);
        chk_info("R2 unknown no change", 1, MAXP);
    endtask

    task automatic t_short_r11();
        pkt[0] = 8'h01; pkt[1] = 8'h00; pkt[2] = 8'h01; run(3);
        chk("R11 short cfg", rb[0], 2);
        pkt[0] = 8'h02; run(1);
        chk("R11 bare write", rb[0], 2);
        chk("R11 cfg kept", cfg_pixels, MAXP);
    endtask

    task automatic t_clear_r8();
        int v, s0;
        do_write(0, 40, 2, 8'h90);
        rd_fb(41, v); chk("R8 pre-clear data", v, 8'h91);
        s0 = n_starts;
        pkt[0] = 8'h03; pkt[1] = 8'h00; run(2);
        chk("R8 clear status", rb[0], 0);
        chk("R8 clear shift", n_starts - s0, 1);
        chk_fb_zero("R8 cleared");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_config_r5();
        t_write_r6();
        t_limit_r7();
        t_index_r3();
        t_cfg_bad_r4();
        t_unknown_r2();
        t_short_r11();
        t_clear_r8();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule